// File: doc/BRIEF.md
# Load-Store Alignment and Extension Unit

This unit sits between a 32-bit core and a byte-addressable 32-bit memory bus. For every load or store it forms the effective address from a base register and a displacement. The displacement is either a sign-extended 16-bit immediate or a second register. The unit presents the word address and the byte-lane enables, and it lays the store data across the lanes. It rejects any request whose address does not match the access size.

The memory returns read data one cycle after a load request. The unit holds the lane offset, size and signedness of an aligned load for that cycle. It then picks the addressed byte or halfword out of the returned word and widens it to 32 bits, with sign or zero extension as requested. A new request can be issued in the same cycle that the previous load's result is being extended.

Top module: `lsu_align_unit`

## Requirements
- R1: With `disp_sel_i`=0 the effective address is `base_i` plus `disp_imm_i` sign-extended to 32 bits. `word_addr_o` is bits [31:2] of that sum.
- R2: With `disp_sel_i`=1 the effective address is `base_i` plus `disp_reg_i`. `word_addr_o` is bits [31:2] of that sum.
- R3: Lanes are little-endian, with address bits [1:0] giving the lane. `size_i` codes: 0 = byte, 1 = halfword, 2 = long, and 3 behaves as long. A byte access enables the single lane 1<<addr[1:0]. A halfword access enables 4'b0011, or 4'b1100 when addr[1]=1. A long access enables 4'b1111. The enables are 0 whenever neither `load_i` nor `store_i` is high.
- R4: `misalign_o` is high when a request is active and is either a halfword with addr[0]=1 or a long with addr[1:0]≠0. A misaligned request drives all lane enables to 0. `misalign_o` is never high while both strobes are low.
- R5: `wdata_o` repeats the low byte of `wdata_i` in all four lanes for byte accesses. It repeats the low halfword in both halves for halfword accesses. It equals `wdata_i` for long accesses.
- R6: `ld_valid_o` is high in the cycle after an aligned request with `load_i`=1 and `store_i`=0. It is low after a store, after a request with both strobes high (which is treated as a store), after a misaligned request and after an idle cycle. `ld_data_o` is 0 whenever `ld_valid_o` is low.
- R7: In a byte load result, `ld_data_o` takes the lane that addr[1:0] selected from `rd_data_i` in the response cycle. The upper 24 bits copy bit 7 of that lane when `signed_i` was 1, and are 0 otherwise.
- R8: In a halfword load result, `ld_data_o` takes the half of `rd_data_i` that addr[1] selected. The upper 16 bits copy bit 15 of that half when `signed_i` was 1, and are 0 otherwise.
- R9: In a long load result, `ld_data_o` equals `rd_data_i` in the response cycle.
- R10: While `rst_ni` is low, `ld_valid_o` and `ld_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load request strobe |
| store_i | input | 1 | Store request strobe |
| base_i | input | 32 | Base register value |
| disp_imm_i | input | 16 | Immediate displacement, sign-extended |
| disp_reg_i | input | 32 | Register displacement |
| disp_sel_i | input | 1 | 0 = immediate displacement, 1 = register displacement |
| size_i | input | 2 | Access size code |
| signed_i | input | 1 | Sign-extend a narrow load |
| wdata_i | input | 32 | Store data, right-aligned |
| rd_data_i | input | 32 | Read word returned one cycle after a load |
| word_addr_o | output | 30 | Word address on the bus |
| byte_en_o | output | 4 | Byte-lane enables |
| wdata_o | output | 32 | Lane-replicated store data |
| ld_data_o | output | 32 | Extended load result |
| ld_valid_o | output | 1 | Load result valid |
| misalign_o | output | 1 | Misaligned request flag |

## Verification
Two functions overlap in time. The request path (address sum, lane enables, misalignment and store replication) handles a new request in the same cycle that the extension path widens the data for the previous load. The bench issues requests back to back, so each cycle carries a fresh request alongside the read word for the one before it. It deliberately places stores, misaligned loads and idle cycles directly after aligned loads. The request-side outputs are compared in the issuing cycle. The load result expected for that request is queued and compared one cycle later against `ld_valid_o` and `ld_data_o`. This exposes any case where the held attributes of the old load are mixed up with the new request.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_LONG = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_imm_i,
  input  logic [ADDR_W-1:0] disp_reg_i,
  input  logic              disp_sel_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] disp;

  assign imm_ext = {{EXT_W{disp_imm_i[DISP_W-1]}}, disp_imm_i};
  assign disp    = disp_sel_i ? disp_reg_i : imm_ext;
  assign ea_o    = base_i + disp;
endmodule

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
  import lsu_align_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]       ea_i,
  input  logic [1:0]              size_i,
  input  logic                    req_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] word_addr_o,
  output logic [DATA_W/8-1:0]     be_o,
  output logic [DATA_W-1:0]       wdata_o,
  output logic                    misalign_o
);
  localparam int unsigned NB    = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(NB);

  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] low_mask;
  logic [OFF_W:0]   span;
  logic [NB-1:0]    be_raw;
  logic             mis;

  assign off         = ea_i[OFF_W-1:0];
  assign word_addr_o = ea_i[ADDR_W-1:OFF_W];

  // low_mask: address bits that must be zero for this size
  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: span = (OFF_W+1)'(1);
      SZ_HALF: span = (OFF_W+1)'(2);
      default: span = (OFF_W+1)'(NB);
    endcase
    low_mask = OFF_W'(span - 1'b1);
  end

  assign mis        = req_i && ((off & low_mask) != '0);
  assign misalign_o = mis;
  assign be_o       = (req_i && !mis) ? be_raw : '0;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [OFF_W-1:0] src;
    logic [OFF_W+2:0] src_bit;
    assign be_raw[i] = ((OFF_W'(i) ^ off) & ~low_mask) == '0;
    assign src       = OFF_W'(i) & low_mask;
    assign src_bit   = {src, 3'b000};
    assign wdata_o[8*i +: 8] = wdata_i[src_bit +: 8];
  end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
  import lsu_align_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]          rd_data_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic [1:0]                 size_i,
  input  logic                       signed_i,
  output logic [DATA_W-1:0]          ld_data_o
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);

  logic [OFF_W+2:0]  sh;
  logic [DATA_W-1:0] shifted;
  logic              sb;

  assign sh      = {off_i, 3'b000};
  assign shifted = rd_data_i >> sh;

  always_comb begin
    sb = 1'b0;
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin
        sb        = signed_i & shifted[7];
        ld_data_o = {{(DATA_W-8){sb}}, shifted[7:0]};
      end
      SZ_HALF: begin
        sb        = signed_i & shifted[15];
        ld_data_o = {{(DATA_W-16){sb}}, shifted[15:0]};
      end
      default: ld_data_o = rd_data_i;
    endcase
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(NB)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    store_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [DISP_W-1:0]       disp_imm_i,
  input  logic [ADDR_W-1:0]       disp_reg_i,
  input  logic                    disp_sel_i,
  input  logic [1:0]              size_i,
  input  logic                    signed_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [DATA_W-1:0]       rd_data_i,
  output logic [ADDR_W-OFF_W-1:0] word_addr_o,
  output logic [NB-1:0]           byte_en_o,
  output logic [DATA_W-1:0]       wdata_o,
  output logic [DATA_W-1:0]       ld_data_o,
  output logic                    ld_valid_o,
  output logic                    misalign_o
);
  logic [ADDR_W-1:0] ea;
  logic              req;
  logic              is_load;
  logic              mis;
  logic              pend_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              sgn_q;
  logic [DATA_W-1:0] ext;

  assign req     = load_i | store_i;
  assign is_load = load_i & ~store_i;  // both strobes: store wins

  lsu_ea_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_ea (
    .base_i     (base_i),
    .disp_imm_i (disp_imm_i),
    .disp_reg_i (disp_reg_i),
    .disp_sel_i (disp_sel_i),
    .ea_o       (ea)
  );

  lsu_lane_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_lane (
    .ea_i        (ea),
    .size_i      (size_i),
    .req_i       (req),
    .wdata_i     (wdata_i),
    .word_addr_o (word_addr_o),
    .be_o        (byte_en_o),
    .wdata_o     (wdata_o),
    .misalign_o  (mis)
  );

  assign misalign_o = mis;

  // response-phase attributes held for the returning read word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      off_q  <= '0;
      size_q <= SZ_BYTE;
      sgn_q  <= 1'b0;
    end else begin
      pend_q <= is_load & ~mis;
      if (is_load && !mis) begin
        off_q  <= ea[OFF_W-1:0];
        size_q <= size_i;
        sgn_q  <= signed_i;
      end
    end
  end

  lsu_load_ext #(.DATA_W(DATA_W)) i_ext (
    .rd_data_i (rd_data_i),
    .off_i     (off_q),
    .size_i    (size_q),
    .signed_i  (sgn_q),
    .ld_data_o (ext)
  );

  assign ld_valid_o = pend_q;
  assign ld_data_o  = pend_q ? ext : '0;
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                load_i,
  input logic                store_i,
  input logic [1:0]          size_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rd_data_i,
  input logic [DATA_W/8-1:0] byte_en_o,
  input logic [DATA_W-1:0]   wdata_o,
  input logic [DATA_W-1:0]   ld_data_o,
  input logic                ld_valid_o,
  input logic                misalign_o
);
  a_r4_misalign_kills_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> byte_en_o == '0);

  a_r3_idle_no_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i || store_i) |-> (byte_en_o == '0 && !misalign_o));

  a_r3_byte_one_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((load_i || store_i) && size_i == 2'd0) |-> $countones(byte_en_o) == 1);

  a_r6_valid_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !store_i && !misalign_o) |=> ld_valid_o);

  a_r6_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && !store_i && !misalign_o) |=> !ld_valid_o);

  a_r6_zero_when_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_o |-> ld_data_o == '0);

  a_r9_long_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_o && $past(size_i[1])) |-> ld_data_o == rd_data_i);

  a_r5_long_store_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i[1] |-> wdata_o == wdata_i);
endmodule

bind lsu_align_unit lsu_align_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .store_i    (store_i),
  .size_i     (size_i),
  .wdata_i    (wdata_i),
  .rd_data_i  (rd_data_i),
  .byte_en_o  (byte_en_o),
  .wdata_o    (wdata_o),
  .ld_data_o  (ld_data_o),
  .ld_valid_o (ld_valid_o),
  .misalign_o (misalign_o)
);

// File: tb/test_lsu_align_unit.sv
module test_lsu_align_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0, store_i = 1'b0, disp_sel_i = 1'b0, signed_i = 1'b0;
  logic [31:0] base_i = '0, disp_reg_i = '0, wdata_i = '0, rd_data_i = '0;
  logic [15:0] disp_imm_i = '0;
  logic [1:0]  size_i = '0;
  logic [29:0] word_addr_o;
  logic [3:0]  byte_en_o;
  logic [31:0] wdata_o, ld_data_o;
  logic        ld_valid_o, misalign_o;

  int n_vec = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [31:0] pend_rd = '0;

  typedef struct {
    int          due;
    int          tag;
    logic        v;
    logic [31:0] d;
  } exp_t;
  exp_t q[$];

  lsu_align_unit i_lsu_align_unit (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  // drive one request; rd is the read word returned for it next cycle
  task automatic apply(logic ld, logic st, logic [31:0] base, logic [15:0] imm,
                       logic [31:0] rg, logic sel, logic [1:0] sz, logic sg,
                       logic [31:0] wd, logic [31:0] rd);
    logic [31:0] ea, ewd, ed;
    logic [1:0]  off;
    logic        mis, req, v;
    logic [3:0]  ebe;
    logic [7:0]  b;
    logic [15:0] h;
    @(negedge clk_i);
    rd_data_i = pend_rd;
    pend_rd = rd;
    load_i = ld; store_i = st; base_i = base; disp_imm_i = imm;
    disp_reg_i = rg; disp_sel_i = sel; size_i = sz; signed_i = sg; wdata_i = wd;
    #1;
    ea  = base + (sel ? rg : {{16{imm[15]}}, imm});
    off = ea[1:0];
    req = ld | st;
    mis = req && ((sz == 2'd1) ? off[0] : (sz[1] ? (off != 2'd0) : 1'b0));
    if (!req || mis)     ebe = 4'b0000;
    else if (sz == 2'd0) ebe = 4'b0001 << off;
    else if (sz == 2'd1) ebe = off[1] ? 4'b1100 : 4'b0011;
    else                 ebe = 4'b1111;
    if (sz == 2'd0)      ewd = {4{wd[7:0]}};
    else if (sz == 2'd1) ewd = {2{wd[15:0]}};
    else                 ewd = wd;
    chk(sel ? "R2 word_addr" : "R1 word_addr", {2'b00, word_addr_o}, {2'b00, ea[31:2]});
    chk("R3 byte_en", {28'd0, byte_en_o}, {28'd0, ebe});
    chk("R4 misalign", {31'd0, misalign_o}, {31'd0, mis});
    chk("R5 wdata", wdata_o, ewd);
    v = ld && !st && !mis;
    b = rd[8*off +: 8];
    h = off[1] ? rd[31:16] : rd[15:0];
    if (!v)              ed = '0;
    else if (sz == 2'd0) ed = {{24{sg & b[7]}}, b};
    else if (sz == 2'd1) ed = {{16{sg & h[15]}}, h};
    else                 ed = rd;
    q.push_back('{due: cyc + 1, tag: (!v ? 6 : (sz == 2'd0 ? 7 : (sz == 2'd1 ? 8 : 9))), v: v, d: ed});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) apply(0, 0, 32'h3, 16'h0, 32'h0, 0, 2'd2, 0, 32'h0, 32'h0);
  endtask

  // monitor: load results due this cycle (R6, R7, R8, R9)
  initial forever begin
    @(negedge clk_i);
    #2;
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk($sformatf("R%0d ld_valid", (e.tag == 6) ? 6 : e.tag), {31'd0, ld_valid_o}, {31'd0, e.v});
      chk($sformatf("R%0d ld_data", e.tag), ld_data_o, e.d);
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    repeat (2) @(negedge clk_i);
    chk("R10 ld_valid in reset", {31'd0, ld_valid_o}, 32'd0);
    chk("R10 ld_data in reset", ld_data_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1, R9: immediate displacement, long load
    apply(1, 0, 32'h1000, 16'h0010, 32'h0, 0, 2'd2, 0, 32'h0, 32'hdeadbeef);
    // R1: negative immediate, long store
    apply(0, 1, 32'h2000, 16'hfffc, 32'h0, 0, 2'd2, 0, 32'h11223344, 32'h0);
    // R2, R7: register displacement, signed byte lane 3
    apply(1, 0, 32'h100, 16'h0, 32'h23, 1, 2'd0, 1, 32'h0, 32'h857f0000);
    // R7: unsigned byte lane 1, back to back
    apply(1, 0, 32'h200, 16'h0001, 32'h0, 0, 2'd0, 0, 32'h0, 32'h0000a500);
    // R8: signed upper half, unsigned lower half, positive signed
    apply(1, 0, 32'h300, 16'h0002, 32'h0, 0, 2'd1, 1, 32'h0, 32'h80011234);
    apply(1, 0, 32'h300, 16'h0000, 32'h0, 0, 2'd1, 0, 32'h0, 32'h0000f00f);
    apply(1, 0, 32'h300, 16'h0000, 32'h0, 0, 2'd1, 1, 32'h0, 32'h12347fff);
    // R5, R3: byte and half stores
    apply(0, 1, 32'h400, 16'h0002, 32'h0, 0, 2'd0, 0, 32'h000000ab, 32'h0);
    apply(0, 1, 32'h400, 16'h0002, 32'h0, 0, 2'd1, 0, 32'h1234beef, 32'h0);
    // R4: misaligned half load after aligned load, misaligned long store/load
    apply(1, 0, 32'h500, 16'h0000, 32'h0, 0, 2'd2, 0, 32'h0, 32'hcafef00d);
    apply(1, 0, 32'h500, 16'h0001, 32'h0, 0, 2'd1, 1, 32'h0, 32'hffffffff);
    apply(0, 1, 32'h500, 16'h0002, 32'h0, 0, 2'd2, 0, 32'h55aa55aa, 32'h0);
    apply(1, 0, 32'h500, 16'h0000, 32'h3, 1, 2'd2, 0, 32'h0, 32'h12345678);
    // R3: size code 3 acts as long
    apply(1, 0, 32'h600, 16'h0000, 32'h0, 0, 2'd3, 1, 32'h0, 32'h80808080);
    // R6: both strobes -> store, no load result
    apply(1, 1, 32'h700, 16'h0000, 32'h0, 0, 2'd2, 0, 32'h01020304, 32'h99999999);
    // R3, R4: idle with misaligned-looking address
    idle(2);
    // mixed patterns, every size and offset
    lf = 32'h1d872b41;
    for (int i = 0; i < 96; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      apply(lf[3], lf[4] & lf[9], {lf[31:12], 12'h0}, {lf[14:2], 1'b0, lf[1:0]},
            {28'h0, lf[11:8]}, lf[5], lf[7:6], lf[10],
            lf ^ 32'h5a5a5a5a, {lf[15:0], lf[31:16]});
    end
    idle(2);
    finish_run();
  end
endmodule